// File: doc/BRIEF.md
# Serial Port Interrupt Flag Register

This block holds the eight-bit interrupt flag register of a serial transmitter/receiver. The serial datapath reports events as single-cycle pulses: break character received, start condition seen, receive data ready, transmit done and transmit buffer empty. The block latches each pulse into its own sticky flag. It also takes the five error status lines, the clear-to-send pin, the frame format code, the transmit pad code, the start-detect enable and the receiver enable as plain inputs.

Software reaches the register over a simple bus with an address, a write strobe, a read strobe and write data. The flag register is read at `FLAG_ADDR`. Each flag has its own clear rule:
- Five of the flags are cleared by writing a one to their bit.
- The receive flag is cleared by a read of the data register at `DATA_ADDR`, or by turning the receiver off.
- The transmit-empty flag is cleared by a write to the data register.

A single interrupt line is the OR of the flags, each qualified by its own bit of an enable mask.

Top module: `uart_irq_flags`

## Requirements
- R1: After reset the register reads 0x00. A read at `FLAG_ADDR` returns the flags with bit 7 error, bit 5 break, bit 4 CTS change, bit 3 receive start, bit 2 receive complete, bit 1 transmit complete and bit 0 transmit empty. Bit 6 always reads 0. Any other address reads 0x00.
- R2: The error flag (bit 7) is set on every clock edge at which any of `err_status_i[4:0]` is high.
- R3: A write at `FLAG_ADDR` clears each of bits 7, 5, 4, 3 and 1 whose write data bit is 1. Zero bits leave a flag unchanged, and bits 2 and 0 ignore flag-register writes.
- R4: `cts_i` passes through two synchronizing flops. A level change sets bit 4 at the third clock edge after the change, and only if `tx_pad_cfg_i` equals 2 at that edge.
- R5: A `brk_evt_i` pulse sets bit 5 only while `frame_fmt_i` is 4 or 5.
- R6: A `start_evt_i` pulse sets bit 3 only while `sof_en_i` is 1.
- R7: A `rx_data_evt_i` pulse sets bit 2 while `rx_en_i` is 1. The flag is cleared by `rd_i` at `DATA_ADDR`. It is held at 0 whenever `rx_en_i` is 0.
- R8: `tx_done_evt_i` sets bit 1. `tx_empty_evt_i` sets bit 0, and a `wr_i` at `DATA_ADDR` clears bit 0.
- R9: When a set event and a clear hit the same flag in the same cycle, the flag ends up set.
- R10: `irq_o` is 1 exactly when some flag bit other than bit 6 is 1 and its `irq_mask_i` bit is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register bus address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Flag register read data |
| err_status_i | input | 5 | Collision, sync field, overflow, framing, parity errors |
| frame_fmt_i | input | 3 | Frame format code |
| tx_pad_cfg_i | input | 2 | Transmit pad configuration code |
| sof_en_i | input | 1 | Start-of-frame detection enable |
| rx_en_i | input | 1 | Receiver enable |
| cts_i | input | 1 | Clear-to-send pin, asynchronous |
| brk_evt_i | input | 1 | Break/sync character received pulse |
| start_evt_i | input | 1 | Start condition pulse |
| rx_data_evt_i | input | 1 | Receive data available pulse |
| tx_done_evt_i | input | 1 | Transmit frame finished, nothing pending |
| tx_empty_evt_i | input | 1 | Transmit data register emptied pulse |
| irq_mask_i | input | 8 | Per-bit interrupt enable |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench uses the default parameters: a six-bit address, `FLAG_ADDR` 0x18, `DATA_ADDR` 0x28 and two synchronizer stages. Random addresses are drawn mostly from these two registers, so flag-register writes and data-register accesses often land in the same cycle as set pulses. This makes the set-over-clear collisions and the receiver-disable clear common rather than rare. With two stages, the three-edge CTS latency can be observed directly, including toggles that arrive while the pad code changes.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned FLAG_W  = 8;
  localparam int unsigned ERR_W   = 5;
  localparam int unsigned B_DRE   = 0;
  localparam int unsigned B_TXC   = 1;
  localparam int unsigned B_RXC   = 2;
  localparam int unsigned B_RXS   = 3;
  localparam int unsigned B_CTSC  = 4;
  localparam int unsigned B_BRK   = 5;
  localparam int unsigned B_ERR   = 7;
  localparam logic [FLAG_W-1:0] IMPL_MASK = 8'hBF;
  localparam logic [FLAG_W-1:0] W1C_MASK  = 8'hBA;
  localparam logic [1:0]        CTS_PAD_CODE = 2'd2;
endpackage

// File: rtl/uart_flag_cell.sv
module uart_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;  // set dominates
    else if (clr_i) q_o <= 1'b0;
  end

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
endmodule

// File: rtl/uart_cts_detect.sv
module uart_cts_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cts_i,
  output logic change_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], cts_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign change_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/uart_irq_flags.sv
module uart_irq_flags
  import uart_irq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 6,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 6'h18,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 6'h28,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [ERR_W-1:0]  err_status_i,
  input  logic [2:0]        frame_fmt_i,
  input  logic [1:0]        tx_pad_cfg_i,
  input  logic              sof_en_i,
  input  logic              rx_en_i,
  input  logic              cts_i,
  input  logic              brk_evt_i,
  input  logic              start_evt_i,
  input  logic              rx_data_evt_i,
  input  logic              tx_done_evt_i,
  input  logic              tx_empty_evt_i,
  input  logic [7:0]        irq_mask_i,
  output logic              irq_o
);
  logic [FLAG_W-1:0] set_v, clr_v, flags;
  logic cts_change, flag_wr, data_wr, data_rd, autobaud;

  uart_cts_detect #(.STAGES(SYNC_STAGES)) u_cts (
    .clk_i(clk_i), .rst_ni(rst_ni), .cts_i(cts_i), .change_o(cts_change)
  );

  assign flag_wr  = wr_i && (addr_i == FLAG_ADDR);
  assign data_wr  = wr_i && (addr_i == DATA_ADDR);
  assign data_rd  = rd_i && (addr_i == DATA_ADDR);
  assign autobaud = (frame_fmt_i == 3'd4) || (frame_fmt_i == 3'd5);

  always_comb begin
    set_v          = '0;
    set_v[B_ERR]   = |err_status_i;
    set_v[B_BRK]   = brk_evt_i && autobaud;
    set_v[B_CTSC]  = cts_change && (tx_pad_cfg_i == CTS_PAD_CODE);
    set_v[B_RXS]   = start_evt_i && sof_en_i;
    set_v[B_RXC]   = rx_data_evt_i && rx_en_i;
    set_v[B_TXC]   = tx_done_evt_i;
    set_v[B_DRE]   = tx_empty_evt_i;
    clr_v          = flag_wr ? (wdata_i & W1C_MASK) : '0;
    clr_v[B_RXC]   = data_rd || !rx_en_i;
    clr_v[B_DRE]   = data_wr;
  end

  for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
    if (IMPL_MASK[b]) begin : g_cell
      uart_flag_cell u_cell (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .set_i(set_v[b]), .clr_i(clr_v[b]), .q_o(flags[b])
      );
    end else begin : g_none
      assign flags[b] = 1'b0;
    end
  end

  assign rdata_o = (addr_i == FLAG_ADDR) ? flags : '0;
  assign irq_o   = |(flags & irq_mask_i & IMPL_MASK);

  assert_err_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|err_status_i) |=> flags[B_ERR]);
  assert_w1c_txc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_wr && wdata_i[B_TXC] && !tx_done_evt_i) |=> !flags[B_TXC]);
  assert_cts_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flags[B_CTSC] && tx_pad_cfg_i != CTS_PAD_CODE && !flag_wr) |=> !flags[B_CTSC]);
  assert_rxc_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !flags[B_RXC]);
  assert_dre_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && !tx_empty_evt_i) |=> !flags[B_DRE]);
  assert_irq_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags == '0) |-> !irq_o);
endmodule

// File: tb/sim_uart_irq_flags.sv
module sim_uart_irq_flags;
  localparam logic [5:0] FA = 6'h18;
  localparam logic [5:0] DA = 6'h28;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] addr = FA;
  logic wr = 0, rd = 0, sof = 0, rxen = 1, cts = 0;
  logic brk = 0, stt = 0, rxd = 0, txd = 0, txe = 0;
  logic [7:0] wdata = 0, mask = 8'hFF, rdata;
  logic [4:0] err = 0;
  logic [2:0] fmt = 0;
  logic [1:0] pad = 0;
  logic irq;
  logic [7:0] m_flags = 0;
  logic s1 = 0, s2 = 0, sp = 0;
  int n_chk = 0, n_bad = 0;

  always #4ns clk = ~clk;

  uart_irq_flags u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .err_status_i(err), .frame_fmt_i(fmt),
    .tx_pad_cfg_i(pad), .sof_en_i(sof), .rx_en_i(rxen), .cts_i(cts),
    .brk_evt_i(brk), .start_evt_i(stt), .rx_data_evt_i(rxd),
    .tx_done_evt_i(txd), .tx_empty_evt_i(txe), .irq_mask_i(mask), .irq_o(irq)
  );

  function automatic logic [7:0] next_flags(logic [7:0] f, logic chg);
    logic [7:0] s = 0, c = 0;
    s[7] = |err;
    s[5] = brk && (fmt == 3'd4 || fmt == 3'd5);
    s[4] = chg && (pad == 2'd2);
    s[3] = stt && sof;
    s[2] = rxd && rxen;
    s[1] = txd;
    s[0] = txe;
    if (wr && addr == FA) c = wdata & 8'hBA;
    c[2] = (rd && addr == DA) || !rxen;
    c[0] = wr && addr == DA;
    return ((f & ~c) | s) & 8'hBF;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(string tag);
    logic chg;
    @(posedge clk);
    chg = s2 ^ sp;
    m_flags = next_flags(m_flags, chg);
    sp = s2; s2 = s1; s1 = cts;
    #2ns;
    chk({tag, " rdata"}, rdata, (addr == FA) ? m_flags : 8'h00);
    chk({tag, " irq"}, {7'd0, irq}, {7'd0, |(m_flags & mask & 8'hBF)});
  endtask

  task automatic idle();
    wr = 0; rd = 0; addr = FA; wdata = 0; err = 0;
    brk = 0; stt = 0; rxd = 0; txd = 0; txe = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    #10ns;
    chk("R1 reset", rdata, 8'h00);
    rst_n = 1'b1;
    step("R1");
    // R8 / R3: DRE set, flag write ignored, data write clears
    txe = 1; step("R8 dre set"); idle();
    wr = 1; wdata = 8'h45; step("R3 no effect on bits 2,0"); idle();
    addr = DA; wr = 1; step("R8 dre clear"); idle(); step("R1 readback");
    // R2 / R3
    err = 5'b01000; step("R2 error set"); idle();
    wr = 1; wdata = 8'h7F; step("R3 zero keeps error"); idle();
    wr = 1; wdata = 8'h80; step("R3 error w1c"); idle();
    // R5
    fmt = 3'd2; brk = 1; step("R5 gated"); idle();
    fmt = 3'd5; brk = 1; step("R5 set"); idle();
    // R6
    sof = 0; stt = 1; step("R6 gated"); idle();
    sof = 1; stt = 1; step("R6 set"); idle();
    // R4
    pad = 2'd1; cts = 1; repeat (4) step("R4 gated");
    pad = 2'd2; cts = 0; repeat (4) step("R4 change");
    // R7
    rxd = 1; step("R7 rxc set"); idle();
    wr = 1; wdata = 8'h04; step("R3 rxc write ignored"); idle();
    addr = DA; rd = 1; step("R7 data read clear"); idle();
    rxd = 1; step("R7 rxc set again"); idle();
    rxen = 0; step("R7 rx disable"); rxen = 1;
    // R9: set and clear same cycle
    txd = 1; wr = 1; wdata = 8'hFF; step("R9 set wins"); idle();
    addr = DA; wr = 1; txe = 1; step("R9 dre set wins"); idle();
    // R10
    mask = 8'h40; step("R10 masked");
    mask = 8'h02; step("R10 enabled");
    mask = 8'h00; step("R10 all off");
    // random
    for (int i = 0; i < 3000; i++) begin
      int a;
      a = $urandom_range(0, 9);
      addr = (a < 5) ? FA : (a < 8) ? DA : 6'($urandom);
      wr = ($urandom_range(0, 3) == 0);
      rd = ($urandom_range(0, 3) == 0);
      wdata = 8'($urandom);
      err = ($urandom_range(0, 7) == 0) ? 5'($urandom) : 5'd0;
      fmt = 3'($urandom); pad = 2'($urandom);
      sof = 1'($urandom); rxen = ($urandom_range(0, 9) != 0);
      if ($urandom_range(0, 3) == 0) cts = ~cts;
      brk = 1'($urandom); stt = 1'($urandom); rxd = 1'($urandom);
      txd = ($urandom_range(0, 3) == 0); txe = ($urandom_range(0, 3) == 0);
      mask = 8'($urandom);
      step("R1-R10 random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule